// File: doc/BRIEF.md
# I2C Master Bridge on Shared GPIO Pins

This block lets a small 8-bit processor drive an I2C bus one byte at a time through four byte-wide registers in its I/O page. Software turns the bus on, loads a 7-bit target address, then either writes a byte to the data register or sets a read trigger. The hardware then runs the whole bus exchange: start condition, address byte with the direction bit, the data byte with its acknowledge, and the stop condition. The processor polls a status register and sees a busy flag and a sticky not-acknowledged flag.

The two bus lines share pins 2 (data) and 3 (clock) of a four-pin GPIO port. While the bus is switched off, every pin belongs to the GPIO logic. While it is on, pins 2 and 3 act as open-drain lines: each one is either pulled low or released. The other two pins stay with GPIO. The bus clock comes from the system clock through a divider parameter. Each bit uses four quarter periods of `DIV` system clocks.

Top module: `i2c_gpio_bridge`

## Requirements
- R1: After reset, every register reads 0x00 (control at 0x04, target address at 0x05, data at 0x06, status at 0x07), and the bus is disabled.
- R2: The control register at 0x04 holds the enable bit in bit 0 and reads it back. Bit 1 is a read trigger that always reads as 0. The target register at 0x05 keeps only the low 7 bits of a write. The status register at 0x07 shows busy in bit 0 and the sticky NACK flag in bit 1. Any other address reads 0x00.
- R3: While disabled, all four pad drive enables and pad output values equal the GPIO request inputs. Pins 0 and 1 follow GPIO at all times. The GPIO input bus always returns the pad input levels.
- R4: While enabled and idle, pins 2 and 3 are released (drive enable low). Whenever the engine pulls a line low, it drives 0.
- R5: A data-register write while enabled and idle sends a start condition, the byte {target, 0}, waits for the slave's acknowledge, sends the written byte MSB first, waits for the acknowledge, and ends with a stop condition.
- R6: Writing the control register with bits 1 and 0 both set, while idle, sends a start, the byte {target, 1}, receives 8 bits MSB first, answers with a NACK (line released), and sends a stop. The received byte can then be read at 0x06.
- R7: Busy rises on the clock edge that accepts the start write. It falls 80*DIV cycles later for a complete exchange, or 44*DIV cycles later when the address is not acknowledged, because the data byte is then skipped and the stop follows at once.
- R8: NACK is cleared when a transfer starts. It is set 38*DIV cycles after the start when the address is not acknowledged, or 74*DIV cycles after the start when the written data byte is not acknowledged. It then holds until the next start.
- R9: Inside address and data bytes, the data line changes only while the clock line is low. Successive clock rising edges within one exchange are 4*DIV cycles apart.
- R10: While busy, writes to any register are ignored. While disabled, a data write or a read trigger starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write access, 0 = read |
| bus_addr | input | 8 | Register offset within the I/O page |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| gpio_out | input | 4 | Output values requested by the GPIO logic |
| gpio_oe | input | 4 | Drive enables requested by the GPIO logic |
| gpio_in | output | 4 | Pad levels returned to the GPIO logic |
| pad_in | input | 4 | Sampled pad levels |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad drive enables |

## Verification
A behavioural slave on the resolved lines tries a write that is fully acknowledged, a read that returns a known byte, an address that no slave claims, and a data byte the slave refuses. These four patterns separate the normal path, the receive path with its closing NACK, the short aborted exchange, and the late setting of the sticky flag. Each runs for a different length, which the per-clock status comparison catches. GPIO patterns applied while the bus is off, and writes issued mid-transfer, show that pin ownership and register gating hold.

// File: rtl/i2c_bridge_pkg.sv
// Shared constants and types for the I2C bridge.
// Assumes an 8-bit register offset space inside the processor's I/O page.
package i2c_bridge_pkg;

    localparam logic [7:0] OFF_CTRL   = 8'h04;
    localparam logic [7:0] OFF_TARGET = 8'h05;
    localparam logic [7:0] OFF_DATA   = 8'h06;
    localparam logic [7:0] OFF_STATUS = 8'h07;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_READ_BIT = 1;

    // Bus exchange phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_ADDR,
        PH_DATA,
        PH_STOP
    } phase_t;

endpackage

// File: rtl/i2c_tick_gen.sv
// Quarter-period tick generator: pulses once every DIV cycles while run is high.
// Assumes DIV >= 2. The counter is held at zero while run is low, so the first
// tick comes exactly DIV cycles after run rises.
module i2c_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count system clocks within one quarter period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/i2c_in_sync.sv
// Multi-flop synchronizer for a pad input level. Resets to 1 (a released line).
// Assumes STAGES >= 1.
module i2c_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw pad level
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // Later stages settle the level
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_engine.sv
// Bus sequencer: runs one single-byte exchange per start pulse.
// Every segment (start, each of 18 bits, stop) is four quarters long:
//   start : q0 both high, q1 data low, q2..q3 clock low
//   bit   : q0 clock low (data set), q1..q2 clock high, q3 clock low;
//           the input is sampled on the tick that ends q1
//   stop  : q0 both low, q1 clock high, q2..q3 data high
// An unacknowledged address skips the data byte. Assumes start comes only while idle.
module i2c_engine
    import i2c_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic       start_rw,
    input  logic [6:0] tgt_addr,
    input  logic [7:0] tx_byte,
    input  logic       sda_s,
    output logic       busy,
    output logic       nack,
    output logic [7:0] rx_byte,
    output logic       sda_rel,
    output logic       scl_rel,
    output logic       in_byte
);
    localparam logic [3:0] ACK_IDX = 4'd8;

    phase_t     phase;
    logic [1:0] q;
    logic [3:0] bit_idx;
    logic [7:0] sh;
    logic [7:0] rx_sh;
    logic       rw_q;
    logic       addr_nak;

    // Phase, quarter and bit sequencing with sampling of the data line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            q        <= 2'd0;
            bit_idx  <= 4'd0;
            sh       <= 8'hFF;
            rx_sh    <= 8'h00;
            rx_byte  <= 8'h00;
            rw_q     <= 1'b0;
            addr_nak <= 1'b0;
            nack     <= 1'b0;
        end else if (start && phase == PH_IDLE) begin
            phase    <= PH_START;
            q        <= 2'd0;
            bit_idx  <= 4'd0;
            rw_q     <= start_rw;
            addr_nak <= 1'b0;
            nack     <= 1'b0;
        end else if (tick) begin
            if (q == 2'd1) begin
                if (phase == PH_ADDR && bit_idx == ACK_IDX) begin
                    addr_nak <= sda_s;
                    if (sda_s) nack <= 1'b1;
                end
                if (phase == PH_DATA) begin
                    if (rw_q && bit_idx != ACK_IDX) rx_sh <= {rx_sh[6:0], sda_s};
                    if (!rw_q && bit_idx == ACK_IDX && sda_s) nack <= 1'b1;
                end
            end
            if (q != 2'd3) begin
                q <= q + 2'd1;
            end else begin
                q <= 2'd0;
                unique case (phase)
                    PH_START: begin
                        phase   <= PH_ADDR;
                        bit_idx <= 4'd0;
                        sh      <= {tgt_addr, rw_q};
                    end
                    PH_ADDR: begin
                        if (bit_idx == ACK_IDX) begin
                            if (addr_nak) begin
                                phase <= PH_STOP;
                            end else begin
                                phase   <= PH_DATA;
                                bit_idx <= 4'd0;
                                sh      <= rw_q ? 8'hFF : tx_byte;
                            end
                        end else begin
                            bit_idx <= bit_idx + 4'd1;
                            sh      <= {sh[6:0], 1'b1};
                        end
                    end
                    PH_DATA: begin
                        if (bit_idx == ACK_IDX) begin
                            phase <= PH_STOP;
                            if (rw_q) rx_byte <= rx_sh;
                        end else begin
                            bit_idx <= bit_idx + 4'd1;
                            sh      <= {sh[6:0], 1'b1};
                        end
                    end
                    PH_STOP:  phase <= PH_IDLE;
                    default:  phase <= PH_IDLE;
                endcase
            end
        end
    end

    // Line levels as a function of phase and quarter (1 = released)
    always_comb begin
        sda_rel = 1'b1;
        scl_rel = 1'b1;
        unique case (phase)
            PH_START: begin
                sda_rel = (q == 2'd0);
                scl_rel = (q == 2'd0) || (q == 2'd1);
            end
            PH_ADDR: begin
                sda_rel = (bit_idx == ACK_IDX) ? 1'b1 : sh[7];
                scl_rel = (q == 2'd1) || (q == 2'd2);
            end
            PH_DATA: begin
                sda_rel = (rw_q || bit_idx == ACK_IDX) ? 1'b1 : sh[7];
                scl_rel = (q == 2'd1) || (q == 2'd2);
            end
            PH_STOP: begin
                sda_rel = (q == 2'd2) || (q == 2'd3);
                scl_rel = (q != 2'd0);
            end
            default: begin
                sda_rel = 1'b1;
                scl_rel = 1'b1;
            end
        endcase
    end

    assign busy    = (phase != PH_IDLE);
    assign in_byte = (phase == PH_ADDR) || (phase == PH_DATA);

endmodule

// File: rtl/i2c_regs.sv
// Processor-facing register file: enable, target address, data, status.
// Assumes single-cycle write strobes; all writes are dropped while busy.
module i2c_regs
    import i2c_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       busy,
    input  logic       nack,
    input  logic [7:0] rx_byte,
    output logic       en,
    output logic       start,
    output logic       start_rw,
    output logic [6:0] tgt_addr,
    output logic [7:0] tx_byte
);
    logic wr_ok;

    assign wr_ok = bus_cs && bus_we && !busy;

    // Register updates on accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            tgt_addr <= 7'd0;
            tx_byte  <= 8'd0;
        end else if (wr_ok) begin
            if (bus_addr == OFF_CTRL)   en       <= bus_wdata[CTRL_EN_BIT];
            if (bus_addr == OFF_TARGET) tgt_addr <= bus_wdata[6:0];
            if (bus_addr == OFF_DATA)   tx_byte  <= bus_wdata;
        end
    end

    // Start request decoding (data write or read trigger)
    always_comb begin
        start    = 1'b0;
        start_rw = 1'b0;
        if (wr_ok) begin
            if (bus_addr == OFF_DATA && en) begin
                start = 1'b1;
            end else if (bus_addr == OFF_CTRL && bus_wdata[CTRL_EN_BIT]
                         && bus_wdata[CTRL_READ_BIT]) begin
                start    = 1'b1;
                start_rw = 1'b1;
            end
        end
    end

    // Read multiplexer
    always_comb begin
        unique case (bus_addr)
            OFF_CTRL:   bus_rdata = {7'd0, en};
            OFF_TARGET: bus_rdata = {1'b0, tgt_addr};
            OFF_DATA:   bus_rdata = rx_byte;
            OFF_STATUS: bus_rdata = {6'd0, nack, busy};
            default:    bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/i2c_pin_mux.sv
// Pin ownership: GPIO requests pass through, except the two bus pins while enabled,
// which become open-drain (drive 0 or release). Assumes SDA_PIN != SCL_PIN.
module i2c_pin_mux #(
    parameter int GPIO_W  = 4,
    parameter int SDA_PIN = 2,
    parameter int SCL_PIN = 3
) (
    input  logic              en,
    input  logic              sda_rel,
    input  logic              scl_rel,
    input  logic [GPIO_W-1:0] gpio_out,
    input  logic [GPIO_W-1:0] gpio_oe,
    output logic [GPIO_W-1:0] pad_out,
    output logic [GPIO_W-1:0] pad_oe
);
    for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
        if (i == SDA_PIN) begin : g_sda
            assign pad_oe[i]  = en ? !sda_rel : gpio_oe[i];
            assign pad_out[i] = en ? 1'b0 : gpio_out[i];
        end else if (i == SCL_PIN) begin : g_scl
            assign pad_oe[i]  = en ? !scl_rel : gpio_oe[i];
            assign pad_out[i] = en ? 1'b0 : gpio_out[i];
        end else begin : g_plain
            assign pad_oe[i]  = gpio_oe[i];
            assign pad_out[i] = gpio_out[i];
        end
    end

endmodule

// File: rtl/i2c_gpio_bridge.sv
// Top level: register file, quarter-tick divider, data-line synchronizer,
// bus sequencer and pin multiplexer. Assumes DIV >= 4 so the synchronizer
// settles well inside the clock-high quarter that precedes sampling.
module i2c_gpio_bridge #(
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int GPIO_W      = 4,
    parameter int SDA_PIN     = 2,
    parameter int SCL_PIN     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [GPIO_W-1:0] gpio_out,
    input  logic [GPIO_W-1:0] gpio_oe,
    output logic [GPIO_W-1:0] gpio_in,
    input  logic [GPIO_W-1:0] pad_in,
    output logic [GPIO_W-1:0] pad_out,
    output logic [GPIO_W-1:0] pad_oe
);
    logic       en, start, start_rw, busy, nack, tick, sda_s;
    logic       sda_rel, scl_rel, in_byte;
    logic [6:0] tgt_addr;
    logic [7:0] tx_byte, rx_byte;

    i2c_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .nack(nack), .rx_byte(rx_byte),
        .en(en), .start(start), .start_rw(start_rw),
        .tgt_addr(tgt_addr), .tx_byte(tx_byte)
    );

    i2c_tick_gen #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    i2c_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in[SDA_PIN]), .q(sda_s)
    );

    i2c_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start(start), .start_rw(start_rw),
        .tgt_addr(tgt_addr), .tx_byte(tx_byte), .sda_s(sda_s),
        .busy(busy), .nack(nack), .rx_byte(rx_byte),
        .sda_rel(sda_rel), .scl_rel(scl_rel), .in_byte(in_byte)
    );

    i2c_pin_mux #(.GPIO_W(GPIO_W), .SDA_PIN(SDA_PIN), .SCL_PIN(SCL_PIN)) u_mux (
        .en(en), .sda_rel(sda_rel), .scl_rel(scl_rel),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign gpio_in = pad_in;

endmodule

// File: rtl/i2c_bridge_checker.sv
// Protocol and ownership properties for the bridge, bound into the top module.
module i2c_bridge_checker #(
    parameter int GPIO_W  = 4,
    parameter int SDA_PIN = 2,
    parameter int SCL_PIN = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              start,
    input logic              busy,
    input logic              nack,
    input logic              sda_rel,
    input logic              scl_rel,
    input logic              in_byte,
    input logic [GPIO_W-1:0] gpio_out,
    input logic [GPIO_W-1:0] gpio_oe,
    input logic [GPIO_W-1:0] pad_out,
    input logic [GPIO_W-1:0] pad_oe
);
    // R3: disabled bus hands every pin to GPIO
    p_gpio_owns_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pad_oe == gpio_oe) && (pad_out == gpio_out));

    // R4: enabled and idle leaves both bus lines released
    p_idle_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !busy) |-> (!pad_oe[SDA_PIN] && !pad_oe[SCL_PIN]));

    // R4: a driven bus line is always driven low
    p_drive_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pad_oe[SCL_PIN]) |-> !pad_out[SCL_PIN]);

    // R7: an accepted start makes the block busy on the next cycle
    p_start_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8: the sticky flag is clear when a transfer begins
    p_nack_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !nack);

    // R9: inside a byte, the data line holds while the clock line is high
    p_sda_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && $past(in_byte) && scl_rel && $past(scl_rel)) |-> $stable(sda_rel));

    // R10: no new start is issued while busy
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

endmodule

bind i2c_gpio_bridge i2c_bridge_checker #(
    .GPIO_W(GPIO_W), .SDA_PIN(SDA_PIN), .SCL_PIN(SCL_PIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .busy(busy), .nack(nack),
    .sda_rel(sda_rel), .scl_rel(scl_rel), .in_byte(in_byte),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/i2c_gpio_bridge_tb_top.sv
// Testbench: behavioural status/pin model compared every clock, plus a
// behavioural slave on the resolved open-drain lines.
module i2c_gpio_bridge_tb_top;
    localparam int DIV = 4;
    localparam logic [6:0] SLV_ADDR = 7'h50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h07, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] gpio_out = 4'h0, gpio_oe = 4'h0, gpio_in;
    logic [3:0] pad_in, pad_out, pad_oe;
    logic [3:0] ext_lvl = 4'hF;
    logic       slv_low = 1'b0;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign pad_in = ((pad_oe & pad_out) | (~pad_oe & ext_lvl)) & ~{1'b0, slv_low, 2'b00};

    i2c_gpio_bridge #(.DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model of status and pin ownership ----------
    bit       en_m, busy_m, nack_m;
    bit [6:0] addr_m;
    int       cyc_m, dur_m, nak_at_m;
    bit       ack_addr = 1, ack_data = 1;

    task automatic launch(input bit rd);
        bit ok;
        ok       = (addr_m == SLV_ADDR) && ack_addr;
        busy_m   = 1; nack_m = 0; cyc_m = 0;
        dur_m    = ok ? 80*DIV : 44*DIV;
        nak_at_m = !ok ? 38*DIV : ((!rd && !ack_data) ? 74*DIV : -1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            en_m = 0; busy_m = 0; nack_m = 0; addr_m = 0; cyc_m = 0;
        end else if (busy_m) begin
            cyc_m++;
            if (cyc_m == nak_at_m) nack_m = 1;
            if (cyc_m == dur_m) busy_m = 0;
        end else if (bus_cs && bus_we) begin
            case (bus_addr)
                8'h04: begin en_m = bus_wdata[0]; if (bus_wdata[1:0] == 2'b11) launch(1); end
                8'h05: addr_m = bus_wdata[6:0];
                8'h06: if (en_m) launch(0);
                default: ;
            endcase
        end
    end

    // Per-clock comparison, a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            if (bus_cs && !bus_we && bus_addr == 8'h07)
                check(bus_rdata == {6'd0, nack_m, busy_m}, "R7/R8 status", bus_rdata, {nack_m, busy_m});
            check(pad_oe[1:0] == gpio_oe[1:0] && pad_out[1:0] == gpio_out[1:0], "R3 low pins",
                  {pad_oe, pad_out}, {gpio_oe, gpio_out});
            if (!en_m)
                check(pad_oe == gpio_oe && pad_out == gpio_out, "R3 disabled mux",
                      {pad_oe, pad_out}, {gpio_oe, gpio_out});
            else if (!busy_m)
                check(pad_oe[3:2] == 2'b00, "R4 idle release", pad_oe, {2'b00, gpio_oe[1:0]});
        end
    end

    // ---------------- behavioural slave ----------------
    bit       prev_scl = 1, prev_sda = 1, in_frame = 0, addressed = 0, rd_mode = 0;
    int       bitcnt = 0, byte_no = 0, frames = 0, last_rise = -1;
    bit [7:0] shift_r = 0, got_addr = 0, got_data = 0, rd_byte = 8'h3C;
    bit       m_ack = 0;

    always @(posedge clk) begin
        bit scl_l, sda_l;
        #5;
        cycles++;
        if (rst_n) begin
            scl_l = pad_oe[3] ? pad_out[3] : ext_lvl[3];
            sda_l = pad_in[2];
            if (prev_scl && scl_l && prev_sda && !sda_l) begin
                in_frame = 1; bitcnt = 0; byte_no = 0; shift_r = 0; last_rise = -1; slv_low = 0;
            end else if (in_frame && prev_scl && scl_l && !prev_sda && sda_l) begin
                in_frame = 0; frames++; slv_low = 0;
            end else if (in_frame && !prev_scl && scl_l) begin
                if (last_rise >= 0)
                    check(cycles - last_rise == 4*DIV, "R9 clock period", cycles - last_rise, 4*DIV);
                last_rise = cycles;
                if (bitcnt < 8) shift_r = {shift_r[6:0], sda_l};
                else if (byte_no == 1 && rd_mode) m_ack = sda_l;
                bitcnt++;
            end else if (in_frame && prev_scl && !scl_l) begin
                if (bitcnt == 8) begin
                    if (byte_no == 0) begin
                        got_addr  = shift_r;
                        addressed = (shift_r[7:1] == SLV_ADDR);
                        rd_mode   = shift_r[0];
                        slv_low   = addressed && ack_addr;
                    end else begin
                        slv_low = 0;
                        if (!rd_mode) begin
                            got_data = shift_r;
                            slv_low  = addressed && ack_data;
                        end
                    end
                end else if (bitcnt == 9) begin
                    slv_low = 0; byte_no++; bitcnt = 0; shift_r = 0;
                    if (rd_mode && addressed && ack_addr && byte_no == 1) slv_low = !rd_byte[7];
                end else if (bitcnt > 0 && rd_mode && addressed && byte_no == 1) begin
                    slv_low = !rd_byte[7-bitcnt];
                end
            end
            prev_scl = scl_l; prev_sda = sda_l;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0; bus_addr = 8'h07;
    endtask

    task automatic bus_rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = a;
        @(posedge clk); #5;
        check(bus_rdata == exp, req, bus_rdata, exp);
        @(negedge clk); bus_addr = 8'h07;
    endtask

    task automatic wait_idle();
        @(posedge clk);
        while (busy_m) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1; bus_cs = 1;

        // R1: reset state
        bus_rd_chk(8'h04, 8'h00, "R1 ctrl");
        bus_rd_chk(8'h05, 8'h00, "R1 target");
        bus_rd_chk(8'h06, 8'h00, "R1 data");
        bus_rd_chk(8'h07, 8'h00, "R1 status");

        // R3: GPIO ownership while disabled, two patterns
        @(negedge clk); ext_lvl = 4'b1010; gpio_oe = 4'b0101; gpio_out = 4'b0011;
        @(posedge clk); #5;
        check(gpio_in == 4'b1011, "R3 gpio_in", gpio_in, 4'b1011);
        check(pad_oe == 4'b0101 && pad_out == 4'b0011, "R3 pad follow", {pad_oe, pad_out}, 8'h53);
        @(negedge clk); ext_lvl = 4'b0110; gpio_oe = 4'b1100; gpio_out = 4'b0100;
        @(posedge clk); #5;
        check(gpio_in == 4'b0110, "R3 gpio_in 2", gpio_in, 4'b0110);

        // R10: data write while disabled starts nothing
        f0 = frames;
        bus_wr(8'h06, 8'h5A);
        repeat (10 * DIV) @(posedge clk); #5;
        check(pad_oe == gpio_oe, "R10 disabled no start", pad_oe, gpio_oe);
        @(negedge clk); ext_lvl = 4'b1100; gpio_oe = 4'b0011; gpio_out = 4'b0000;

        // R2: register readback
        bus_wr(8'h05, 8'hD0);
        bus_rd_chk(8'h05, 8'h50, "R2 target 7-bit");
        bus_wr(8'h04, 8'h01);
        bus_rd_chk(8'h04, 8'h01, "R2 ctrl enable");
        bus_rd_chk(8'h10, 8'h00, "R2 unmapped");
        @(posedge clk); #5;
        check(pad_oe == 4'b0011, "R4 enabled idle", pad_oe, 4'b0011);

        // R5/R7: acknowledged write
        bus_wr(8'h06, 8'hA5);
        wait_idle();
        check(got_addr == 8'hA0, "R5 address byte", got_addr, 8'hA0);
        check(got_data == 8'hA5, "R5 data byte", got_data, 8'hA5);
        check(frames == f0 + 1, "R5 stop seen", frames, f0 + 1);
        bus_rd_chk(8'h07, 8'h00, "R8 no nack");

        // R6: read of a known byte
        rd_byte = 8'h3C;
        bus_wr(8'h04, 8'h03);
        wait_idle();
        check(got_addr == 8'hA1, "R6 address byte", got_addr, 8'hA1);
        check(m_ack == 1'b1, "R6 master nack", m_ack, 1);
        bus_rd_chk(8'h06, 8'h3C, "R6 received byte");
        bus_rd_chk(8'h04, 8'h01, "R2 trigger reads 0");

        // R8/R7/R10: unclaimed address, with writes issued mid-transfer
        bus_wr(8'h05, 8'h11);
        bus_wr(8'h06, 8'h99);
        bus_wr(8'h05, 8'h22);
        bus_wr(8'h06, 8'h77);
        bus_wr(8'h04, 8'h00);
        wait_idle();
        bus_rd_chk(8'h07, 8'h02, "R8 address nack");
        bus_rd_chk(8'h05, 8'h11, "R10 target kept");
        bus_rd_chk(8'h04, 8'h01, "R10 ctrl kept");
        check(frames == f0 + 3, "R7 short frame count", frames, f0 + 3);

        // R8: refused data byte, then cleared by next start
        bus_wr(8'h05, 8'h50);
        ack_data = 0;
        bus_wr(8'h06, 8'h0F);
        wait_idle();
        bus_rd_chk(8'h07, 8'h02, "R8 data nack");
        check(got_data == 8'h0F, "R5 refused data byte", got_data, 8'h0F);
        ack_data = 1;
        rd_byte = 8'hC3;
        bus_wr(8'h04, 8'h03);
        wait_idle();
        bus_rd_chk(8'h07, 8'h00, "R8 cleared on start");
        bus_rd_chk(8'h06, 8'hC3, "R6 second byte");

        // R3: disable returns pins to GPIO
        bus_wr(8'h04, 8'h00);
        @(negedge clk); gpio_oe = 4'b1110; gpio_out = 4'b1010;
        @(posedge clk); #5;
        check(pad_oe == 4'b1110 && pad_out == 4'b1010, "R3 after disable", {pad_oe, pad_out}, 8'hEA);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule